// File: doc/BRIEF.md
# Trap Entry Unit

This block carries out the architectural state change that happens at the moment a hart accepts a trap. The core presents the trap's kind (interrupt or exception), its cause code, the faulting address, the current program counter and privilege, the status word, the two delegation masks and the two handler-base registers. On the clock edge where the take strobe is high, the unit chooses whether the supervisor or the machine handler runs and updates that level's interrupt-enable stack, cause, exception PC and trap value. It also produces the handler address and the privilege the hart runs at next.

Two cause-shaping steps come before the level choice. An environment call always arrives as code 8 and is renamed after the privilege it was issued from. A failed address translation, flagged separately, is turned into a page-fault or access-fault code for the access kind. The unit also keeps the load-reservation valid flag and drops it whenever a trap changes privilege.

Privilege encoding is user 0, supervisor 1, machine 3. Status bit positions are supervisor interrupt enable 1, machine interrupt enable 3, supervisor previous enable 5, machine previous enable 7, supervisor previous privilege 8, and machine previous privilege 12:11.

Top module: `trap_entry_unit`

## Requirements
- R1: The delegation mask used is `int_deleg_i` when the effective trap is an interrupt, and `exc_deleg_i` when it is an exception.
- R2: The trap goes to supervisor (new privilege 1) only if the current privilege is 0 or 1, the effective cause is below XLEN and its bit in the selected mask is 1. In every other case it goes to machine (new privilege 3).
- R3: For the chosen level, the previous-enable bit (5 or 7) takes the old enable bit (1 or 3). The previous-privilege field (bit 8 takes priv[0], bits 12:11 take priv) takes the current privilege. The enable bit is cleared. All other status bits are copied from `status_i`.
- R4: The chosen level's cause register gets the effective cause zero-extended, with bit XLEN-1 set for interrupts. Its exception PC gets `cur_pc_i`. The other level's cause, exception PC and trap value registers keep their values.
- R5: The chosen level's trap value gets `fault_addr_i` only for exception causes 0, 1, 4, 5, 6, 7, 12, 13 and 15. It is 0 for all other exceptions and for every interrupt.
- R6: An exception with cause 8 is recorded as 8 from user, 9 from supervisor and 11 from machine.
- R7: The new PC is the chosen level's vector register with bits 1:0 cleared. When the trap is an interrupt and the vector register's bits 1:0 equal 1, 4 × cause is added. Any other mode value adds nothing.
- R8: When `xlat_fail_i` is high, the trap is an exception whatever `async_i` holds. Its cause for access kind fetch(0), load(1 or 3) or store(2) is 12, 13 or 15 if `paging_on_i` is high and `xlat_prot_i` is low, and 1, 5 or 7 otherwise.
- R9: `rsv_set_i` sets the reservation flag. A taken trap whose new privilege differs from `cur_priv_i` clears it, and the clear wins over a set on the same edge. A trap that keeps the privilege leaves the flag as it is.
- R10: All outputs are registered and change together only on an edge with `take_i` high (the reservation flag also on `rsv_set_i`). After reset the PC is RESET_PC, the privilege is 3 and every other output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| take_i | input | 1 | Take the trap on this edge |
| async_i | input | 1 | Trap is an interrupt |
| cause_i | input | CW | Raw cause code |
| xlat_fail_i | input | 1 | Address translation failed |
| xlat_prot_i | input | 1 | Failure came from a protection check |
| paging_on_i | input | 1 | Paged translation is active |
| acc_type_i | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| fault_addr_i | input | XLEN | Faulting address |
| cur_pc_i | input | XLEN | PC of the trapping instruction |
| cur_priv_i | input | 2 | Current privilege |
| status_i | input | XLEN | Current status word |
| int_deleg_i | input | XLEN | Interrupt delegation mask |
| exc_deleg_i | input | XLEN | Exception delegation mask |
| svec_i | input | XLEN | Supervisor handler base and mode |
| mvec_i | input | XLEN | Machine handler base and mode |
| rsv_set_i | input | 1 | Set the load-reservation flag |
| new_pc_o | output | XLEN | Handler address |
| new_priv_o | output | 2 | Privilege after the trap |
| status_o | output | XLEN | Updated status word |
| scause_o | output | XLEN | Supervisor cause |
| sepc_o | output | XLEN | Supervisor exception PC |
| stval_o | output | XLEN | Supervisor trap value |
| mcause_o | output | XLEN | Machine cause |
| mepc_o | output | XLEN | Machine exception PC |
| mtval_o | output | XLEN | Machine trap value |
| rsv_valid_o | output | 1 | Load-reservation valid flag |

## Verification
The bench builds the unit with XLEN = 32, which makes the cause port six bits wide. Codes 32 to 63 can then be driven, so the bench reaches the case where a cause at or above the register width must go to machine even under an all-ones delegation mask. The 32-bit width also keeps handler offsets such as 4 × 7 easy to predict. A non-zero RESET_PC makes the reset value of the PC output tell a missing reset apart from a cleared one.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

    typedef enum logic [1:0] {
        PRIV_U = 2'd0,
        PRIV_S = 2'd1,
        PRIV_R = 2'd2,
        PRIV_M = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_ALT   = 2'd3
    } acc_e;

    localparam int unsigned EC_FETCH_MISAL = 0;
    localparam int unsigned EC_FETCH_ACC   = 1;
    localparam int unsigned EC_LOAD_MISAL  = 4;
    localparam int unsigned EC_LOAD_ACC    = 5;
    localparam int unsigned EC_STORE_MISAL = 6;
    localparam int unsigned EC_STORE_ACC   = 7;
    localparam int unsigned EC_ENVCALL     = 8;
    localparam int unsigned EC_FETCH_PAGE  = 12;
    localparam int unsigned EC_LOAD_PAGE   = 13;
    localparam int unsigned EC_STORE_PAGE  = 15;

    localparam int unsigned SB_SIE   = 1;
    localparam int unsigned SB_MIE   = 3;
    localparam int unsigned SB_SPIE  = 5;
    localparam int unsigned SB_MPIE  = 7;
    localparam int unsigned SB_SPP   = 8;
    localparam int unsigned SB_MPP_L = 11;
    localparam int unsigned SB_MPP_H = 12;

endpackage

// File: rtl/trap_cause_resolve.sv
module trap_cause_resolve
    import trap_entry_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int CW   = $clog2(XLEN) + 1
) (
    input  logic            async_i,
    input  logic [CW-1:0]   cause_i,
    input  logic            xlat_fail_i,
    input  logic            xlat_prot_i,
    input  logic            paging_on_i,
    input  logic [1:0]      acc_type_i,
    input  logic [1:0]      cur_priv_i,
    input  logic [XLEN-1:0] fault_addr_i,
    output logic            eff_async_o,
    output logic [CW-1:0]   eff_cause_o,
    output logic [XLEN-1:0] tval_o
);

    logic page_kind;
    logic addr_bearing;

    always_comb begin
        page_kind   = paging_on_i && !xlat_prot_i;
        eff_async_o = async_i && !xlat_fail_i;
        eff_cause_o = cause_i;
        if (xlat_fail_i) begin
            unique case (acc_type_i)
                ACC_FETCH: eff_cause_o = page_kind ? CW'(EC_FETCH_PAGE) : CW'(EC_FETCH_ACC);
                ACC_STORE: eff_cause_o = page_kind ? CW'(EC_STORE_PAGE) : CW'(EC_STORE_ACC);
                default:   eff_cause_o = page_kind ? CW'(EC_LOAD_PAGE)  : CW'(EC_LOAD_ACC);
            endcase
        end else if (!async_i && cause_i == CW'(EC_ENVCALL)) begin
            eff_cause_o = CW'(EC_ENVCALL) + CW'(cur_priv_i);
        end
    end

    always_comb begin
        unique case (eff_cause_o)
            CW'(EC_FETCH_MISAL), CW'(EC_FETCH_ACC),
            CW'(EC_LOAD_MISAL),  CW'(EC_LOAD_ACC),
            CW'(EC_STORE_MISAL), CW'(EC_STORE_ACC),
            CW'(EC_FETCH_PAGE),  CW'(EC_LOAD_PAGE),
            CW'(EC_STORE_PAGE):  addr_bearing = 1'b1;
            default:             addr_bearing = 1'b0;
        endcase
        tval_o = (!eff_async_o && addr_bearing) ? fault_addr_i : '0;
    end

endmodule

// File: rtl/trap_level_pick.sv
module trap_level_pick
    import trap_entry_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int CW   = $clog2(XLEN) + 1
) (
    input  logic            eff_async_i,
    input  logic [CW-1:0]   eff_cause_i,
    input  logic [1:0]      cur_priv_i,
    input  logic [XLEN-1:0] int_deleg_i,
    input  logic [XLEN-1:0] exc_deleg_i,
    input  logic [XLEN-1:0] svec_i,
    input  logic [XLEN-1:0] mvec_i,
    output logic            to_super_o,
    output logic [XLEN-1:0] vec_pc_o
);

    localparam logic [1:0] MODE_SPREAD = 2'b01;

    logic [XLEN-1:0] mask;
    logic [XLEN-1:0] hit;
    logic [XLEN-1:0] vec_sel;
    logic [XLEN-1:0] vec_base;
    logic [XLEN-1:0] vec_off;

    assign mask = eff_async_i ? int_deleg_i : exc_deleg_i;

    // one comparator per mask bit; a cause at or above XLEN matches none
    for (genvar b = 0; b < XLEN; b++) begin : g_hit
        assign hit[b] = mask[b] && (eff_cause_i == CW'(b));
    end

    always_comb begin
        to_super_o = (cur_priv_i == PRIV_U || cur_priv_i == PRIV_S) && (|hit);
        vec_sel    = to_super_o ? svec_i : mvec_i;
        vec_base   = {vec_sel[XLEN-1:2], 2'b00};
        vec_off    = (eff_async_i && vec_sel[1:0] == MODE_SPREAD)
                   ? (XLEN'(eff_cause_i) << 2) : '0;
        vec_pc_o   = vec_base + vec_off;
    end

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_entry_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              CW       = $clog2(XLEN) + 1,
    parameter logic [XLEN-1:0] RESET_PC = XLEN'(32'h0000_1000)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_i,
    input  logic            async_i,
    input  logic [CW-1:0]   cause_i,
    input  logic            xlat_fail_i,
    input  logic            xlat_prot_i,
    input  logic            paging_on_i,
    input  logic [1:0]      acc_type_i,
    input  logic [XLEN-1:0] fault_addr_i,
    input  logic [XLEN-1:0] cur_pc_i,
    input  logic [1:0]      cur_priv_i,
    input  logic [XLEN-1:0] status_i,
    input  logic [XLEN-1:0] int_deleg_i,
    input  logic [XLEN-1:0] exc_deleg_i,
    input  logic [XLEN-1:0] svec_i,
    input  logic [XLEN-1:0] mvec_i,
    input  logic            rsv_set_i,
    output logic [XLEN-1:0] new_pc_o,
    output logic [1:0]      new_priv_o,
    output logic [XLEN-1:0] status_o,
    output logic [XLEN-1:0] scause_o,
    output logic [XLEN-1:0] sepc_o,
    output logic [XLEN-1:0] stval_o,
    output logic [XLEN-1:0] mcause_o,
    output logic [XLEN-1:0] mepc_o,
    output logic [XLEN-1:0] mtval_o,
    output logic            rsv_valid_o
);

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [1:0]      priv;
        logic [XLEN-1:0] status;
        logic [XLEN-1:0] scause;
        logic [XLEN-1:0] sepc;
        logic [XLEN-1:0] stval;
        logic [XLEN-1:0] mcause;
        logic [XLEN-1:0] mepc;
        logic [XLEN-1:0] mtval;
        logic            rsv;
    } arch_t;

    arch_t st_d, st_q;

    logic            eff_async;
    logic [CW-1:0]   eff_cause;
    logic [XLEN-1:0] tval;
    logic            to_super;
    logic [XLEN-1:0] vec_pc;
    logic [XLEN-1:0] cause_word;

    trap_cause_resolve #(.XLEN(XLEN), .CW(CW)) i_resolve (
        .async_i      (async_i),
        .cause_i      (cause_i),
        .xlat_fail_i  (xlat_fail_i),
        .xlat_prot_i  (xlat_prot_i),
        .paging_on_i  (paging_on_i),
        .acc_type_i   (acc_type_i),
        .cur_priv_i   (cur_priv_i),
        .fault_addr_i (fault_addr_i),
        .eff_async_o  (eff_async),
        .eff_cause_o  (eff_cause),
        .tval_o       (tval)
    );

    trap_level_pick #(.XLEN(XLEN), .CW(CW)) i_pick (
        .eff_async_i  (eff_async),
        .eff_cause_i  (eff_cause),
        .cur_priv_i   (cur_priv_i),
        .int_deleg_i  (int_deleg_i),
        .exc_deleg_i  (exc_deleg_i),
        .svec_i       (svec_i),
        .mvec_i       (mvec_i),
        .to_super_o   (to_super),
        .vec_pc_o     (vec_pc)
    );

    always_comb begin
        cause_word             = {{(XLEN-CW){1'b0}}, eff_cause};
        cause_word[XLEN-1]     = eff_async;

        st_d = st_q;
        if (rsv_set_i) begin
            st_d.rsv = 1'b1;
        end
        if (take_i) begin
            st_d.pc     = vec_pc;
            st_d.status = status_i;
            if (to_super) begin
                st_d.status[SB_SPIE] = status_i[SB_SIE];
                st_d.status[SB_SPP]  = cur_priv_i[0];
                st_d.status[SB_SIE]  = 1'b0;
                st_d.scause          = cause_word;
                st_d.sepc            = cur_pc_i;
                st_d.stval           = tval;
                st_d.priv            = PRIV_S;
            end else begin
                st_d.status[SB_MPIE]            = status_i[SB_MIE];
                st_d.status[SB_MPP_H:SB_MPP_L]  = cur_priv_i;
                st_d.status[SB_MIE]             = 1'b0;
                st_d.mcause                     = cause_word;
                st_d.mepc                       = cur_pc_i;
                st_d.mtval                      = tval;
                st_d.priv                       = PRIV_M;
            end
            if (st_d.priv != cur_priv_i) begin
                st_d.rsv = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.pc   <= RESET_PC;
            st_q.priv <= PRIV_M;
        end else begin
            st_q <= st_d;
        end
    end

    assign new_pc_o    = st_q.pc;
    assign new_priv_o  = st_q.priv;
    assign status_o    = st_q.status;
    assign scause_o    = st_q.scause;
    assign sepc_o      = st_q.sepc;
    assign stval_o     = st_q.stval;
    assign mcause_o    = st_q.mcause;
    assign mepc_o      = st_q.mepc;
    assign mtval_o     = st_q.mtval;
    assign rsv_valid_o = st_q.rsv;

endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            take_i,
    input logic            async_i,
    input logic            xlat_fail_i,
    input logic [XLEN-1:0] cur_pc_i,
    input logic [1:0]      cur_priv_i,
    input logic [XLEN-1:0] new_pc_o,
    input logic [1:0]      new_priv_o,
    input logic [XLEN-1:0] status_o,
    input logic [XLEN-1:0] scause_o,
    input logic [XLEN-1:0] sepc_o,
    input logic [XLEN-1:0] mcause_o,
    input logic [XLEN-1:0] mepc_o,
    input logic            rsv_valid_o
);

    AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> ((new_priv_o == 2'd3) ? mepc_o : sepc_o) == $past(cur_pc_i)); // R4

    AST_ASYNC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> ((new_priv_o == 2'd3) ? mcause_o[XLEN-1] : scause_o[XLEN-1])
                   == $past(async_i && !xlat_fail_i)); // R4

    AST_MACHINE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && cur_priv_i == 2'd3) |=> new_priv_o == 2'd3); // R2

    AST_ONLY_TWO_TARGETS: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> (new_priv_o == 2'd3 || new_priv_o == 2'd1)); // R2

    AST_ENABLE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> ((new_priv_o == 2'd3) ? !status_o[3] : !status_o[1])); // R3

    AST_SYNC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && (!async_i || xlat_fail_i)) |=> new_pc_o[1:0] == 2'b00); // R7

    AST_RSV_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> (new_priv_o == $past(cur_priv_i)) || !rsv_valid_o); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> $stable(new_pc_o) && $stable(new_priv_o) && $stable(status_o)
                    && $stable(mcause_o) && $stable(scause_o)); // R10

endmodule

bind trap_entry_unit trap_entry_chk #(.XLEN(XLEN)) i_chk (.*);

// File: tb/test_trap_entry_unit.sv
`timescale 1ns/1ps
module test_trap_entry_unit;

    localparam int XLEN = 32;
    localparam int CW   = $clog2(XLEN) + 1;
    localparam logic [31:0] RST_PC = 32'h0000_1000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            take_i = 1'b0;
    logic            async_i = 1'b0;
    logic [CW-1:0]   cause_i = '0;
    logic            xlat_fail_i = 1'b0;
    logic            xlat_prot_i = 1'b0;
    logic            paging_on_i = 1'b0;
    logic [1:0]      acc_type_i = 2'd0;
    logic [31:0]     fault_addr_i = '0;
    logic [31:0]     cur_pc_i = '0;
    logic [1:0]      cur_priv_i = 2'd3;
    logic [31:0]     status_i = '0;
    logic [31:0]     int_deleg_i = '0;
    logic [31:0]     exc_deleg_i = '0;
    logic [31:0]     svec_i = '0;
    logic [31:0]     mvec_i = '0;
    logic            rsv_set_i = 1'b0;
    logic [31:0]     new_pc_o, status_o, scause_o, sepc_o, stval_o, mcause_o, mepc_o, mtval_o;
    logic [1:0]      new_priv_o;
    logic            rsv_valid_o;

    always #4 clk = ~clk;

    trap_entry_unit #(.XLEN(XLEN), .CW(CW), .RESET_PC(RST_PC)) i_trap_entry_unit (.*);

    typedef struct {
        logic [31:0] pc;
        logic [1:0]  priv;
        logic [31:0] status, scause, sepc, stval, mcause, mepc, mtval;
        logic        rsv;
        string       tag;
    } exp_t;

    exp_t m;
    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(exp_t e);
        chk(e.tag, "pc",     new_pc_o, e.pc);
        chk(e.tag, "priv",   {30'd0, new_priv_o}, {30'd0, e.priv});
        chk(e.tag, "status", status_o, e.status);
        chk(e.tag, "scause", scause_o, e.scause);
        chk(e.tag, "sepc",   sepc_o, e.sepc);
        chk(e.tag, "stval",  stval_o, e.stval);
        chk(e.tag, "mcause", mcause_o, e.mcause);
        chk(e.tag, "mepc",   mepc_o, e.mepc);
        chk(e.tag, "mtval",  mtval_o, e.mtval);
        chk(e.tag, "rsv",    {31'd0, rsv_valid_o}, {31'd0, e.rsv});
    endtask

    function automatic bit addr_code(int c);
        return c == 0 || c == 1 || c == 4 || c == 5 || c == 6 || c == 7
            || c == 12 || c == 13 || c == 15;
    endfunction

    // driver: computes the expected state from the requirements, then pulses take
    task automatic fire(string tag);
        bit          ea;
        int          ec;
        bit          tos;
        logic [31:0] dm, vec, cw, tv;
        ea = async_i && !xlat_fail_i;
        ec = int'(cause_i);
        if (xlat_fail_i) begin                                    // R8
            bit pg = paging_on_i && !xlat_prot_i;
            if (acc_type_i == 2'd0)      ec = pg ? 12 : 1;
            else if (acc_type_i == 2'd2) ec = pg ? 15 : 7;
            else                         ec = pg ? 13 : 5;
        end else if (!async_i && ec == 8) begin                   // R6
            ec = 8 + int'(cur_priv_i);
        end
        dm  = ea ? int_deleg_i : exc_deleg_i;                     // R1
        tos = (cur_priv_i <= 2'd1) && ec < 32 && dm[ec % 32];     // R2
        vec = tos ? svec_i : mvec_i;
        m.pc = {vec[31:2], 2'b00} + ((ea && vec[1:0] == 2'b01) ? 32'(ec * 4) : 32'd0); // R7
        tv = (!ea && addr_code(ec)) ? fault_addr_i : 32'd0;       // R5
        cw = 32'(ec);
        cw[31] = ea;
        m.status = status_i;
        if (tos) begin
            m.status[5] = status_i[1]; m.status[8] = cur_priv_i[0]; m.status[1] = 1'b0;
            m.scause = cw; m.sepc = cur_pc_i; m.stval = tv; m.priv = 2'd1;
        end else begin
            m.status[7] = status_i[3]; m.status[12:11] = cur_priv_i; m.status[3] = 1'b0;
            m.mcause = cw; m.mepc = cur_pc_i; m.mtval = tv; m.priv = 2'd3;
        end
        m.rsv = m.rsv | rsv_set_i;
        if (m.priv != cur_priv_i) m.rsv = 1'b0;                  // R9
        m.tag = tag;
        q.push_back(m);
        take_i = 1'b1;
        @(negedge clk);
        take_i = 1'b0;
        rsv_set_i = 1'b0;
    endtask

    // monitor: pops the expectation for every edge on which take was high
    initial begin
        forever begin
            @(posedge clk);
            if (take_i) begin
                @(negedge clk);
                if (q.size() == 0) begin
                    n_chk++; n_fail++;
                    $display("FAIL R10 unexpected trap result actual=1 expected=0");
                end else begin
                    compare_all(q.pop_front());
                end
            end
        end
    end

    task automatic setup(bit as, int c, logic [1:0] pr, logic [31:0] pc, logic [31:0] fa);
        async_i = as; cause_i = CW'(c); cur_priv_i = pr; cur_pc_i = pc; fault_addr_i = fa;
        xlat_fail_i = 1'b0; xlat_prot_i = 1'b0; paging_on_i = 1'b0; acc_type_i = 2'd0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        m = '{pc: RST_PC, priv: 2'd3, status: 0, scause: 0, sepc: 0, stval: 0,
              mcause: 0, mepc: 0, mtval: 0, rsv: 0, tag: "R10 reset"};
        repeat (3) @(negedge clk);
        compare_all(m);                                           // R10 reset values
        rst_n = 1'b1;
        @(negedge clk);

        svec_i = 32'h0000_8001; mvec_i = 32'h0000_4001;
        status_i = 32'h0000_000A;

        // R1 R2 R5: sync load access fault from user, delegated
        exc_deleg_i = 32'h0000_0020;
        setup(1'b0, 5, 2'd0, 32'h0000_0100, 32'hDEAD_0004);
        fire("R1 R2 R5 sync delegated");
        // R2: same cause from machine stays in machine
        setup(1'b0, 5, 2'd3, 32'h0000_0200, 32'hDEAD_0008);
        fire("R2 machine not delegated");
        // R1 R7: interrupt 5 delegated through interrupt mask, spread vector
        exc_deleg_i = 32'h0; int_deleg_i = 32'h0000_0020;
        setup(1'b1, 5, 2'd0, 32'h0000_0300, 32'h1111_1111);
        fire("R1 R7 R4 async to supervisor");
        // R5 R7: interrupt 7 from supervisor, not delegated, tval zero
        setup(1'b1, 7, 2'd1, 32'h0000_0304, 32'h2222_2222);
        fire("R5 R7 async to machine");
        // R7: mode 0 and mode 2 give no offset
        mvec_i = 32'h0000_4000;
        setup(1'b1, 7, 2'd3, 32'h0000_0308, 32'h0);
        fire("R7 direct mode");
        mvec_i = 32'h0000_4002;
        setup(1'b1, 11, 2'd3, 32'h0000_030C, 32'h0);
        fire("R7 reserved mode");
        // R6: environment call from each privilege
        mvec_i = 32'h0000_4001;
        setup(1'b0, 8, 2'd0, 32'h0000_0400, 32'h3333_3333); fire("R6 ecall user");
        setup(1'b0, 8, 2'd1, 32'h0000_0404, 32'h3333_3333); fire("R6 ecall supervisor");
        setup(1'b0, 8, 2'd3, 32'h0000_0408, 32'h3333_3333); fire("R6 ecall machine");
        // R8: translation failures, async input must be ignored
        setup(1'b1, 3, 2'd3, 32'h0000_0500, 32'hABCD_0010);
        xlat_fail_i = 1'b1; paging_on_i = 1'b1; acc_type_i = 2'd2;
        fire("R8 store page fault");
        setup(1'b0, 3, 2'd3, 32'h0000_0504, 32'hABCD_0020);
        xlat_fail_i = 1'b1; paging_on_i = 1'b1; xlat_prot_i = 1'b1; acc_type_i = 2'd2;
        fire("R8 store protection access fault");
        setup(1'b0, 3, 2'd3, 32'h0000_0508, 32'hABCD_0030);
        xlat_fail_i = 1'b1; acc_type_i = 2'd0;
        fire("R8 fetch access fault bare");
        setup(1'b0, 3, 2'd3, 32'h0000_050C, 32'hABCD_0040);
        xlat_fail_i = 1'b1; paging_on_i = 1'b1; acc_type_i = 2'd3;
        fire("R8 load page fault");
        // R2: cause at or above the width never delegates
        exc_deleg_i = 32'hFFFF_FFFF;
        setup(1'b0, 40, 2'd0, 32'h0000_0600, 32'h4444_4444);
        fire("R2 R5 wide cause to machine");
        // R5: delegated illegal-style cause 2 carries no address
        setup(1'b0, 2, 2'd0, 32'h0000_0604, 32'h5555_5555);
        fire("R5 R3 non-address cause");
        // R9: set flag, check, then a priv change clears it
        setup(1'b0, 5, 2'd0, 32'h0, 32'h0);
        rsv_set_i = 1'b1; @(negedge clk); rsv_set_i = 1'b0; m.rsv = 1'b1;
        chk("R9", "rsv set", {31'd0, rsv_valid_o}, 32'd1);
        setup(1'b0, 5, 2'd0, 32'h0000_0700, 32'h6666_0000);
        fire("R9 change clears");
        rsv_set_i = 1'b1; @(negedge clk); rsv_set_i = 1'b0; m.rsv = 1'b1;
        exc_deleg_i = 32'h0;
        setup(1'b0, 5, 2'd3, 32'h0000_0704, 32'h6666_0004);
        fire("R9 same priv keeps");
        setup(1'b0, 5, 2'd1, 32'h0000_0708, 32'h6666_0008);
        rsv_set_i = 1'b1;
        fire("R9 clear beats set");
        // R10: inputs move without take, outputs hold
        for (int k = 0; k < 3; k++) begin
            setup(k[0], 3 + k, 2'(k), 32'h9000_0000 + 32'(k), 32'hFFFF_0000);
            status_i = 32'hFFFF_FFFF;
            @(negedge clk);
        end
        m.tag = "R10 hold";
        compare_all(m);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule